// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Unit

This block holds the status register of a small serial NOR flash slave and decides which write-type operations are allowed. It watches the SPI pins in the system clock domain. It answers a status-read command by shifting the status byte out. It takes write-enable and status-write commands. Through a request port, it tells the array controller whether a page program, sector erase or bulk erase may start.

Two protect bits and a status-write-disable bit are the non-volatile part of the register. A separate power-on reset clears them, and the ordinary reset leaves them alone. While the disable bit is 1 and the write-protect pin is low, those bits are frozen. The protect bits cover a region of the four 64 KB sectors, starting at the top of the array. Bulk erase is refused unless both protect bits are 0.

The SPI pins (`spi_cs_n`, `spi_sclk`, `spi_mosi`) must already be synchronous to `clk`. Each SCLK half period must last at least two `clk` cycles. The interface uses SPI mode 0: input is sampled on the rising SCLK edge and output changes after the falling edge.

Top module: `flash_status_guard`

## Requirements
- R1: After chip select falls, the opcode 0x05 is shifted in MSB first on rising SCLK edges. The status byte then appears on `spi_miso` MSB first, one bit after each following falling SCLK edge. `spi_miso_oe` stays 0 during the opcode byte and while chip select is high.
- R2: While chip select stays low after a status read, the current status byte is sent again and again.
- R3: The status byte has SRWD in bit 7, protect bits BP[1:0] in bits 3:2, the write-enable latch (WEL) in bit 1 and `array_busy` in bit 0. All other bits read 0.
- R4: Opcode 0x06 sets WEL when chip select rises after a whole number of bytes.
- R5: Opcode 0x01 followed by a data byte is a status write. It is accepted only when WEL is 1 and the block is not hardware protected. When accepted, it loads SRWD from data bit 7 and BP from data bits 3:2, and it clears WEL. When WEL is 0, it changes nothing.
- R6: The block is hardware protected while SRWD is 1 and `wp_n` is 0. A status write in this mode is not executed: SRWD, BP and WEL are all left unchanged.
- R7: A command is discarded when chip select rises after a bit count that is not a multiple of 8.
- R8: `req_cmd` codes are 0 for page program, 1 for sector erase, 2 for bulk erase and 3 for reserved (always refused). For program and sector erase, the sector is `req_addr[17:16]`. BP = 0 protects no sector, 1 protects sector 3, 2 protects sectors 2 and 3, and 3 protects all four sectors. A protected sector is refused.
- R9: A bulk erase is granted only when BP is 0.
- R10: A request is answered in the cycle after `req_valid`: `req_done` is 1 and `req_grant` gives the decision. A grant needs WEL to be 1 and clears WEL.
- R11: `rst_n` clears WEL and the SPI state but keeps SRWD and BP. `por_n` clears SRWD and BP.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset for volatile state |
| por_n | input | 1 | Active-low power-on reset for the non-volatile bits |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (0 means high impedance) |
| wp_n | input | 1 | Write-protect pin, active low |
| array_busy | input | 1 | Write-in-progress flag from the array controller |
| req_valid | input | 1 | Program or erase request strobe |
| req_cmd | input | 2 | Request kind: 0 program, 1 sector erase, 2 bulk erase |
| req_addr | input | 18 | Target byte address |
| req_done | output | 1 | Request answered (one cycle after `req_valid`) |
| req_grant | output | 1 | Request may proceed |

## Verification
A wrong protect bit does not stay hidden. It shows up in the next status read, and it flips the grant decision for whole sectors in the first request that follows. A stuck or wrongly cleared WEL changes the grant within one cycle of a request. A lost status write shows up in the next read of bit 7 and bits 3:2. Shifter slips give a rotated status byte, either in the first byte or in the repeated one, so every status read also checks the bit order.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WREN = 8'h06;

    typedef enum logic [1:0] {
        REQ_PROGRAM = 2'd0,
        REQ_SECTOR  = 2'd1,
        REQ_BULK    = 2'd2,
        REQ_NONE    = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic       srwd;
        logic [1:0] bp;
    } nv_bits_t;

    function automatic logic [7:0] pack_status(nv_bits_t nv, logic wel, logic wip);
        return {nv.srwd, 3'b000, nv.bp, wel, wip};
    endfunction
endpackage

// File: rtl/fsg_spi_shift.sv
module fsg_spi_shift
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic [7:0] status_i,
    output logic       so_o,
    output logic       so_oe_o,
    output logic       end_o,
    output logic [7:0] opcode_o,
    output logic [7:0] wdata_o,
    output logic [1:0] nbytes_o
);
    typedef struct packed {
        logic       sclk;
        logic       cs_n;
        logic [7:0] sh;
        logic [2:0] bidx;
        logic [1:0] nbytes;
        logic [7:0] opcode;
        logic [7:0] wdata;
        logic       rd;
        logic       reload;
        logic [7:0] oshift;
        logic       so;
        logic       oe;
        logic       endp;
    } spi_st_t;

    spi_st_t st_d, st_q;
    logic    rise, fall;
    logic [7:0] byte_in;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk_i;
        st_d.cs_n = cs_n_i;
        st_d.endp = 1'b0;
        rise      = sclk_i && !st_q.sclk;
        fall      = !sclk_i && st_q.sclk;
        byte_in   = {st_q.sh[6:0], mosi_i};
        if (cs_n_i) begin
            st_d.rd     = 1'b0;
            st_d.reload = 1'b0;
            st_d.oe     = 1'b0;
            if (!st_q.cs_n && st_q.bidx == 3'd0 && st_q.nbytes != 2'd0)
                st_d.endp = 1'b1;
        end else if (st_q.cs_n) begin
            st_d.bidx   = 3'd0;
            st_d.nbytes = 2'd0;
            st_d.opcode = 8'h00;
            st_d.rd     = 1'b0;
            st_d.reload = 1'b0;
        end else begin
            if (rise) begin
                st_d.sh   = byte_in;
                st_d.bidx = st_q.bidx + 3'd1;
                if (st_q.bidx == 3'd7) begin
                    if (st_q.nbytes == 2'd0) st_d.opcode = byte_in;
                    if (st_q.nbytes == 2'd1) st_d.wdata  = byte_in;
                    if (st_q.nbytes != 2'd3) st_d.nbytes = st_q.nbytes + 2'd1;
                    if (st_q.rd || (st_q.nbytes == 2'd0 && byte_in == OP_RDSR)) begin
                        st_d.rd     = 1'b1;
                        st_d.reload = 1'b1;
                    end
                end
            end
            if (fall && st_q.rd) begin
                st_d.oe = 1'b1;
                if (st_q.reload) begin
                    st_d.so     = status_i[7];
                    st_d.oshift = {status_i[6:0], 1'b0};
                    st_d.reload = 1'b0;
                end else begin
                    st_d.so     = st_q.oshift[7];
                    st_d.oshift = {st_q.oshift[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign so_o     = st_q.so;
    assign so_oe_o  = st_q.oe;
    assign end_o    = st_q.endp;
    assign opcode_o = st_q.opcode;
    assign wdata_o  = st_q.wdata;
    assign nbytes_o = st_q.nbytes;

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i)) |-> !so_oe_o); // R1
    AST_END_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> (st_q.bidx == 3'd0)); // R7
endmodule

// File: rtl/fsg_region_guard.sv
module fsg_region_guard
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 2
) (
    input  logic [1:0]        bp_i,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              allow_o
);
    localparam int NSECT = 1 << SECT_W;

    logic [SECT_W-1:0] sector;
    int unsigned       prot_cnt;

    always_comb begin
        sector   = addr_i[ADDR_W-1 -: SECT_W];
        prot_cnt = (bp_i == 2'd0) ? 0 : (NSECT >> (3 - int'(bp_i)));
        case (kind_i)
            REQ_PROGRAM,
            REQ_SECTOR: allow_o = (int'(sector) + int'(prot_cnt)) < NSECT;
            REQ_BULK:   allow_o = (bp_i == 2'd0);
            default:    allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wp_n,
    input  logic              array_busy,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_done,
    output logic              req_grant
);
    typedef struct packed {
        logic wel;
        logic done;
        logic grant;
    } vol_st_t;

    vol_st_t  vol_d, vol_q;
    nv_bits_t nv_d, nv_q;

    logic       cmd_end;
    logic [7:0] cmd_op, cmd_data, status_byte;
    logic [1:0] cmd_bytes;
    logic       allow, hw_locked;

    assign status_byte = pack_status(nv_q, vol_q.wel, array_busy);
    assign hw_locked   = nv_q.srwd && !wp_n;

    fsg_spi_shift u_spi (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (spi_sclk),
        .cs_n_i   (spi_cs_n),
        .mosi_i   (spi_mosi),
        .status_i (status_byte),
        .so_o     (spi_miso),
        .so_oe_o  (spi_miso_oe),
        .end_o    (cmd_end),
        .opcode_o (cmd_op),
        .wdata_o  (cmd_data),
        .nbytes_o (cmd_bytes)
    );

    fsg_region_guard #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_guard (
        .bp_i    (nv_q.bp),
        .kind_i  (req_cmd),
        .addr_i  (req_addr),
        .allow_o (allow)
    );

    always_comb begin
        vol_d = vol_q;
        nv_d  = nv_q;
        if (cmd_end) begin
            if (cmd_op == OP_WREN) vol_d.wel = 1'b1;
            if (cmd_op == OP_WRSR && cmd_bytes >= 2'd2 && vol_q.wel && !hw_locked) begin
                nv_d.srwd = cmd_data[7];
                nv_d.bp   = cmd_data[3:2];
                vol_d.wel = 1'b0;
            end
        end
        vol_d.done  = req_valid;
        vol_d.grant = req_valid && vol_q.wel && allow;
        if (vol_d.grant) vol_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vol_q <= '0;
        else        vol_q <= vol_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) nv_q <= '0;
        else        nv_q <= nv_d;
    end

    assign req_done  = vol_q.done;
    assign req_grant = vol_q.grant;

    AST_HW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (nv_q.srwd && !wp_n) |=> $stable(nv_q)); // R6
    AST_NV_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !vol_q.wel |=> $stable(nv_q)); // R5
    AST_BULK_LOCK: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (req_valid && req_cmd == 2'd2 && nv_q.bp != 2'd0) |=> !req_grant); // R9
    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (req_valid && nv_q.bp == 2'd3) |=> !req_grant); // R8
    AST_GRANT_WEL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (req_valid && !vol_q.wel) |=> (req_done && !req_grant)); // R10
endmodule

// File: tb/flash_status_guard_tb.sv
module flash_status_guard_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_oe;
    logic wp_n = 1'b1, busy = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_cmd = 2'd0;
    logic [17:0] req_addr = '0;
    logic req_done, req_grant;

    int checks = 0, errors = 0;
    logic m_srwd = 1'b0, m_wel = 1'b0;
    logic [1:0] m_bp = 2'd0;

    always #2 clk = ~clk;

    flash_status_guard u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .wp_n(wp_n), .array_busy(busy),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_done(req_done), .req_grant(req_grant)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output logic oe_seen);
        rx = 8'h00;
        oe_seen = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = tx[7-i];
            wait_n(4);
            rx = {rx[6:0], miso};
            oe_seen = oe_seen | miso_oe;
            sclk = 1'b1;
            wait_n(4);
        end
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        wait_n(4);
    endtask

    task automatic cs_stop();
        sclk = 1'b0;
        wait_n(4);
        cs_n = 1'b1;
        wait_n(6);
    endtask

    task automatic send_cmd(input logic [7:0] op, input int nbits);
        logic [7:0] rx;
        logic oe;
        cs_start();
        xfer(op, nbits, rx, oe);
        cs_stop();
    endtask

    task automatic send_wrsr(input logic [7:0] data);
        logic [7:0] rx;
        logic oe;
        cs_start();
        xfer(8'h01, 8, rx, oe);
        xfer(data, 8, rx, oe);
        cs_stop();
    endtask

    function automatic logic [7:0] model_status();
        return {m_srwd, 3'b000, m_bp, m_wel, busy};
    endfunction

    task automatic read_status(input string req, input int repeats);
        logic [7:0] rx;
        logic oe;
        cs_start();
        xfer(8'h05, 8, rx, oe);
        check(oe == 1'b0, "R1 oe during opcode", oe, 0);
        for (int r = 0; r < repeats; r++) begin
            xfer(8'h00, 8, rx, oe);
            check(rx == model_status() && oe, req, rx, model_status());
        end
        cs_stop();
        check(miso_oe == 1'b0, "R1 oe after deselect", miso_oe, 0);
    endtask

    task automatic set_status(input logic [7:0] data);
        send_cmd(8'h06, 8);
        send_wrsr(data);
        m_srwd = data[7];
        m_bp = data[3:2];
        m_wel = 1'b0;
    endtask

    task automatic request(input logic [1:0] kind, input logic [17:0] addr, input bit exp, input string req);
        req_valid = 1'b1;
        req_cmd = kind;
        req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_done == 1'b1, "R10 done", req_done, 1);
        check(req_grant == exp, req, req_grant, exp);
        if (exp) m_wel = 1'b0;
        wait_n(2);
    endtask

    function automatic int prot_count(input logic [1:0] bp);
        return (bp == 2'd0) ? 0 : (4 >> (3 - int'(bp)));
    endfunction

    initial begin
        wait_n(5);
        por_n = 1'b1;
        rst_n = 1'b1;
        wait_n(3);
        check(miso_oe == 1'b0 && req_done == 1'b0 && req_grant == 1'b0, "R11 reset outputs",
              {miso_oe, req_done, req_grant}, 0);
        read_status("R3 status after power-on", 1);

        // R7: partial opcode is dropped; R4: whole byte sets latch
        send_cmd(8'h06, 7);
        read_status("R7 partial WREN dropped", 1);
        send_cmd(8'h06, 8);
        m_wel = 1'b1;
        read_status("R4 WREN sets WEL", 1);
        busy = 1'b1;
        read_status("R3 busy shown in bit 0", 2);
        busy = 1'b0;

        // R5: status write without latch is ignored
        send_cmd(8'h06, 8);
        send_wrsr(8'h8C);
        m_srwd = 1'b1; m_bp = 2'd3; m_wel = 1'b0;
        read_status("R5 WRSR loads fields", 1);
        send_wrsr(8'h00);
        read_status("R5 WRSR without WEL ignored", 1);

        // R7: status write cut off mid data byte
        send_cmd(8'h06, 8);
        m_wel = 1'b1;
        begin
            logic [7:0] rx;
            logic oe;
            cs_start();
            xfer(8'h01, 8, rx, oe);
            xfer(8'h00, 5, rx, oe);
            cs_stop();
        end
        read_status("R7 partial WRSR dropped", 1);

        // R6: hardware lock
        wp_n = 1'b0;
        send_wrsr(8'h00);
        read_status("R6 locked WRSR ignored, WEL kept", 1);
        wp_n = 1'b1;
        send_wrsr(8'h00);
        m_srwd = 1'b0; m_bp = 2'd0; m_wel = 1'b0;
        read_status("R6 unlocked WRSR accepted", 1);

        // R2: continuous read
        read_status("R2 repeated status byte", 3);

        // R8 R9 R10: sweep every protect setting and target
        for (int bp = 0; bp < 4; bp++) begin
            set_status({4'b0000, 2'(bp), 2'b00});
            request(2'd0, 18'h0, 1'b0, "R10 no grant without WEL");
            for (int sec = 0; sec < 4; sec++) begin
                for (int k = 0; k < 2; k++) begin
                    send_cmd(8'h06, 8);
                    m_wel = 1'b1;
                    request(2'(k), {2'(sec), 16'h1234}, (sec + prot_count(2'(bp))) < 4,
                            "R8 sector decision");
                    read_status("R10 WEL after request", 1);
                    if (m_wel) begin
                        m_wel = 1'b1;
                    end
                end
            end
            send_cmd(8'h06, 8);
            m_wel = 1'b1;
            request(2'd2, 18'h0, bp == 0, "R9 bulk erase decision");
            request(2'd3, 18'h0, 1'b0, "R8 reserved refused");
            m_wel = (bp == 0) ? 1'b0 : 1'b1;
            read_status("R9 WEL after bulk", 1);
            send_cmd(8'h04, 8);
        end

        // R11: ordinary reset keeps protect bits
        set_status(8'h88);
        send_cmd(8'h06, 8);
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(2);
        m_wel = 1'b0;
        read_status("R11 rst_n keeps SRWD/BP", 1);
        por_n = 1'b0;
        wait_n(2);
        por_n = 1'b1;
        wait_n(2);
        m_srwd = 1'b0; m_bp = 2'd0;
        read_status("R11 por_n clears SRWD/BP", 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule